// File: doc/BRIEF.md
# Parallel DAC Power-Mode Sequencer

This block sits on the host side of an 8-bit parallel-input digital-to-analog converter that is clocked from the same clock as the block. It drives the converter's sample bus, its active-low chip select and its two mode pins: a power-down pin and an enable pin. It moves the converter between three power states, off, idle and running, in response to commands. Samples arrive on a valid/ready stream, and each accepted sample goes onto the bus on the next clock edge.

Leaving a low-power state needs a settling wait, and its length depends on the state being left. Leaving off takes about 50 µs. Leaving idle takes 0.5 µs. The wait lengths are computed from the system clock frequency, and the stream stays stalled until the wait has ended. The converter stores each bus value in an input latch and then in its output register. The block follows that two-edge delay and raises a one-cycle `out_valid` flag, together with the code now present at the analog output.

Top module: `dac_pwr_seq`

## Requirements
- R1: Reset sets these values and they stay until a run command arrives: `mode_st`=00, `dac_pd`=1, `dac_en`=0, `dac_cs_n`=1, `s_ready`=0, `out_valid`=0, `dac_data`=0.
- R2: The mode pins follow `mode_st`. Code 00 (off) drives `dac_pd`=1 and `dac_en`=0. Code 01 (idle) drives `dac_pd`=0 and `dac_en`=0. Codes 10 (waking) and 11 (running) drive `dac_pd`=0 and `dac_en`=1. `dac_cs_n` is low only in codes 10 and 11.
- R3: A run command in off changes `mode_st` to 10 at the same edge. It stays at 10 for exactly LONG_CYC = ceil(SHDN_WAIT_NS·CLK_HZ/1e9) cycles (5000 by default) and then becomes 11.
- R4: A run command in idle gives a waking period of exactly SHORT_CYC = ceil(STBY_WAIT_NS·CLK_HZ/1e9) cycles (50 by default).
- R5: An idle or off command during waking ends the wait at once. The mode goes to 01 or 00. A later run command starts a complete new wait, whose length matches the state being left.
- R6: `s_ready` is high only while `mode_st`=11. `dac_data` changes only at an edge where `s_valid` and `s_ready` are both high, and it then takes `s_data`. Otherwise it holds its value.
- R7: A sample accepted at edge k gives `out_valid`=1 for the single cycle after edge k+2, with `out_code` equal to that sample.
- R8: Commands are read only when `cmd_valid`=1. `cmd_op` 01 is run, 10 is idle, 11 is off, and 00 does nothing. A run command while waking or running has no effect: it neither restarts nor shortens the wait.
- R9: When the mode leaves running, samples still inside the converter's two-stage pipeline produce no `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the converter's sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code: 00 none, 01 run, 10 idle, 11 off |
| s_valid | input | 1 | Sample stream valid |
| s_data | input | DATA_W | Sample stream data |
| s_ready | output | 1 | Sample stream ready, high only while running |
| dac_data | output | DATA_W | Converter sample bus |
| dac_cs_n | output | 1 | Converter chip select, active low |
| dac_pd | output | 1 | Converter power-down pin |
| dac_en | output | 1 | Converter enable pin |
| out_valid | output | 1 | Pulse: the converter output has just taken a new code |
| out_code | output | DATA_W | Code now present at the converter output |
| mode_st | output | 2 | Mode: 00 off, 01 idle, 10 waking, 11 running |

## Verification
A command changes `mode_st` and the pins at the edge that samples it. The bench therefore drives a command, waits one edge and reads the new mode 1 ns later. A waking period is measured by counting cycles from that first sample until the mode reads 11, and the count is compared with the exact cycle figure. An accepted sample appears on `dac_data` one edge after acceptance and on `out_valid`/`out_code` two edges after that. The table rows give the expected pulse two rows after the sample that causes it. All samples are taken 1 ns after the rising edge, and inputs are changed only at that time.

// File: rtl/dac_seq_pkg.sv
// Shared types and helpers for the DAC power-mode sequencer.
// Assumes the converter is clocked by the same clock as this logic.
package dac_seq_pkg;

    // Mode code, also the value reported on the status output.
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_IDLE = 2'b01,
        MODE_WAKE = 2'b10,
        MODE_RUN  = 2'b11
    } mode_e;

    // Command codes carried on cmd_op.
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_RUN  = 2'b01,
        OP_IDLE = 2'b10,
        OP_OFF  = 2'b11
    } op_e;

    // Number of whole clock cycles covering ns nanoseconds at hz, never below 2.
    function automatic int wait_cycles(longint hz, longint ns);
        longint c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (c < 2) c = 2;
        return int'(c);
    endfunction

endpackage

// File: rtl/dac_wake_timer.sv
// Settling-wait counter. A load picks the long wait (leaving off) or the
// short wait (leaving idle). The count runs down only while 'active' is high.
// Assumes both wait lengths are at least 2 cycles.
module dac_wake_timer #(
    parameter int LONG_CYC  = 5000,
    parameter int SHORT_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic long_sel,
    input  logic active,
    output logic done
);
    localparam int CW = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] LONG_INIT  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] SHORT_INIT = CW'(SHORT_CYC - 1);

    logic [CW-1:0] cnt;

    // Load on a wake request, then count down to zero while waking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= long_sel ? LONG_INIT : SHORT_INIT;
        end else if (active && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/dac_mode_fsm.sv
// Power-mode state machine. Decodes commands, starts the wake timer and
// drives the converter's mode pins and chip select from the registered mode.
// Assumes the timer's 'done' is valid one cycle after a load.
module dac_mode_fsm
    import dac_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       wait_done,
    output mode_e      mode,
    output logic       tmr_load,
    output logic       tmr_long,
    output logic       pd,
    output logic       en,
    output logic       cs_n
);
    mode_e nxt;
    op_e   op;

    assign op = op_e'(cmd_op);

    // Next-mode decision: a finished wait first, then commands override.
    always_comb begin
        nxt      = mode;
        tmr_load = 1'b0;
        tmr_long = 1'b0;
        if (mode == MODE_WAKE && wait_done) begin
            nxt = MODE_RUN;
        end
        if (cmd_valid) begin
            case (op)
                OP_RUN: begin
                    if (mode == MODE_OFF) begin
                        nxt      = MODE_WAKE;
                        tmr_load = 1'b1;
                        tmr_long = 1'b1;
                    end else if (mode == MODE_IDLE) begin
                        nxt      = MODE_WAKE;
                        tmr_load = 1'b1;
                    end
                end
                OP_IDLE: nxt = MODE_IDLE;
                OP_OFF:  nxt = MODE_OFF;
                default: ;
            endcase
        end
    end

    // Mode register; reset leaves the converter fully off.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= MODE_OFF;
        else        mode <= nxt;
    end

    // Pin decode from the registered mode, so the pins never glitch.
    always_comb begin
        pd   = (mode == MODE_OFF);
        en   = (mode == MODE_WAKE) || (mode == MODE_RUN);
        cs_n = !en;
    end
endmodule

// File: rtl/dac_sample_pipe.sv
// Sample path. Accepts a stream beat only while running, holds the bus
// between beats, and follows the converter's internal register stages so
// that out_valid rises when the analog output takes the code.
// Assumes the converter captures on every rising edge of the shared clock.
module dac_sample_pipe #(
    parameter int DATA_W = 8,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    output logic [DATA_W-1:0] dac_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_code
);
    logic              accept;
    logic              acc_q;
    logic [LAT-1:0]    stg_v;
    logic [DATA_W-1:0] stg_d [LAT];

    assign s_ready = run;
    assign accept  = s_valid && run;

    // Present an accepted sample on the bus and mark it as in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_data <= '0;
            acc_q    <= 1'b0;
        end else begin
            acc_q <= accept;
            if (accept) dac_data <= s_data;
        end
    end

    // One tracking stage per converter register; flushed when not running.
    for (genvar i = 0; i < LAT; i++) begin : g_stage
        logic              src_v;
        logic [DATA_W-1:0] src_d;
        if (i == 0) begin : g_first
            assign src_v = acc_q;
            assign src_d = dac_data;
        end else begin : g_next
            assign src_v = stg_v[i-1];
            assign src_d = stg_d[i-1];
        end
        // Shift the in-flight flag and code one converter stage onward.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_v[i] <= 1'b0;
                stg_d[i] <= '0;
            end else begin
                stg_v[i] <= run ? src_v : 1'b0;
                stg_d[i] <= src_d;
            end
        end
    end

    assign out_valid = stg_v[LAT-1];
    assign out_code  = stg_d[LAT-1];
endmodule

// File: rtl/dac_pwr_seq.sv
// Top of the DAC power-mode sequencer: mode FSM, wake timer and sample path.
// Assumes the converter shares clk and that clk meets its period limits.
module dac_pwr_seq
    import dac_seq_pkg::*;
#(
    parameter int     DATA_W       = 8,
    parameter longint CLK_HZ       = 100_000_000,
    parameter longint SHDN_WAIT_NS = 50_000,
    parameter longint STBY_WAIT_NS = 500,
    parameter int     PIPE_LAT     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_cs_n,
    output logic              dac_pd,
    output logic              dac_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_code,
    output logic [1:0]        mode_st
);
    localparam int LONG_CYC  = wait_cycles(CLK_HZ, SHDN_WAIT_NS);
    localparam int SHORT_CYC = wait_cycles(CLK_HZ, STBY_WAIT_NS);

    mode_e mode;
    logic  tmr_load, tmr_long, tmr_done;

    dac_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .wait_done (tmr_done),
        .mode      (mode),
        .tmr_load  (tmr_load),
        .tmr_long  (tmr_long),
        .pd        (dac_pd),
        .en        (dac_en),
        .cs_n      (dac_cs_n)
    );

    dac_wake_timer #(
        .LONG_CYC  (LONG_CYC),
        .SHORT_CYC (SHORT_CYC)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .long_sel (tmr_long),
        .active   (mode == MODE_WAKE),
        .done     (tmr_done)
    );

    dac_sample_pipe #(
        .DATA_W (DATA_W),
        .LAT    (PIPE_LAT)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (mode == MODE_RUN),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_ready   (s_ready),
        .dac_data  (dac_data),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

    assign mode_st = mode;
endmodule

// File: rtl/dac_pwr_seq_chk.sv
// Port-level checker for dac_pwr_seq, attached by bind.
// Assumes the default pipeline depth of two converter registers.
module dac_pwr_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              s_valid,
    input logic [DATA_W-1:0] s_data,
    input logic              s_ready,
    input logic [DATA_W-1:0] dac_data,
    input logic              dac_cs_n,
    input logic              dac_pd,
    input logic              dac_en,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_code,
    input logic [1:0]        mode_st
);
    AST_OFF_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_st == 2'b00) |-> (dac_pd && !dac_en && dac_cs_n)); // R2

    AST_READY_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (mode_st == 2'b11)); // R6

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_valid && s_ready) |=> $stable(dac_data)); // R6

    AST_RUN_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_st == 2'b11 && $past(mode_st) != 2'b11) |-> ($past(mode_st) == 2'b10)); // R3

    AST_OV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(s_valid && s_ready, 3)); // R7

    AST_OV_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_code == $past(s_data, 3))); // R7

    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_st == 2'b11 && !(cmd_valid && cmd_op[1])) |=> (mode_st == 2'b11)); // R8
endmodule

bind dac_pwr_seq dac_pwr_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .s_valid   (s_valid),
    .s_data    (s_data),
    .s_ready   (s_ready),
    .dac_data  (dac_data),
    .dac_cs_n  (dac_cs_n),
    .dac_pd    (dac_pd),
    .dac_en    (dac_en),
    .out_valid (out_valid),
    .out_code  (out_code),
    .mode_st   (mode_st)
);

// File: tb/tb_dac_pwr_seq.sv
// Self-checking bench for dac_pwr_seq with default parameters.
module tb_dac_pwr_seq;
    localparam int LONG_EXP  = 5000;
    localparam int SHORT_EXP = 50;
    localparam int NVEC      = 10;
    // {s_valid, s_data, expected dac_data, expected out_valid, expected out_code}
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b1, 8'hA5, 8'hA5, 1'b0, 8'h00},
        {1'b0, 8'h3C, 8'hA5, 1'b0, 8'h00},
        {1'b1, 8'h3C, 8'h3C, 1'b1, 8'hA5},
        {1'b1, 8'hFF, 8'hFF, 1'b0, 8'h00},
        {1'b1, 8'h00, 8'h00, 1'b1, 8'h3C},
        {1'b0, 8'h77, 8'h00, 1'b1, 8'hFF},
        {1'b0, 8'h11, 8'h00, 1'b1, 8'h00},
        {1'b1, 8'h80, 8'h80, 1'b0, 8'h00},
        {1'b0, 8'h00, 8'h80, 1'b0, 8'h00},
        {1'b0, 8'h00, 8'h80, 1'b1, 8'h80}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_ready, dac_cs_n, dac_pd, dac_en, out_valid;
    logic [7:0] dac_data, out_code;
    logic [1:0] mode_st;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dac_pwr_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .dac_data(dac_data), .dac_cs_n(dac_cs_n), .dac_pd(dac_pd),
        .dac_en(dac_en), .out_valid(out_valid), .out_code(out_code),
        .mode_st(mode_st)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op);
        cmd_valid = 1'b1;
        cmd_op    = op;
        step();
        cmd_valid = 1'b0;
        cmd_op    = 2'b00;
    endtask

    // Count cycles spent waking; optionally repeat a run command at cycle 'poke'.
    task automatic wake_len(input int poke, output int n);
        n = 0;
        for (int i = 0; i < 20000; i++) begin
            if (mode_st != 2'b10) break;
            n++;
            if (poke == n) begin
                cmd_valid = 1'b1;
                cmd_op    = 2'b01;
            end
            step();
            cmd_valid = 1'b0;
            cmd_op    = 2'b00;
        end
    endtask

    // Pins as a packed value {pd, en, cs_n}.
    function automatic int pins();
        return {dac_pd, dac_en, dac_cs_n};
    endfunction

    initial begin
        int n;
        int bad;
        step(); step(); step();
        chk("R1 mode", mode_st, 0);
        chk("R1 pins", pins(), 3'b101);
        chk("R1 ready/valid/data", {s_ready, out_valid, dac_data}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) step();
        chk("R1 stays off", mode_st, 0);

        cmd_valid = 1'b1; cmd_op = 2'b00; step(); cmd_valid = 1'b0;
        chk("R8 no-op code", mode_st, 0);
        cmd_op = 2'b01; step(); cmd_op = 2'b00;
        chk("R8 strobe low ignored", mode_st, 0);

        send(2'b01);
        chk("R3 waking", mode_st, 2'b10);
        chk("R2 waking pins", pins(), 3'b010);
        chk("R6 ready low waking", s_ready, 0);
        wake_len(0, n);
        chk("R3 long wait cycles", n, LONG_EXP);
        chk("R2 running pins", pins(), 3'b010);
        chk("R6 ready running", s_ready, 1);

        for (int i = 0; i < NVEC; i++) begin
            s_valid = VEC[i][25];
            s_data  = VEC[i][24:17];
            step();
            chk("R6 bus", dac_data, VEC[i][16:9]);
            chk("R7 out_valid", out_valid, VEC[i][8]);
            if (VEC[i][8]) chk("R7 out_code", out_code, VEC[i][7:0]);
        end
        s_valid = 1'b0;

        send(2'b01);
        chk("R8 run while running", mode_st, 2'b11);

        send(2'b10);
        chk("R2 idle mode", mode_st, 2'b01);
        chk("R2 idle pins", pins(), 3'b001);
        chk("R6 ready low idle", s_ready, 0);
        s_valid = 1'b1; s_data = 8'h5A; step(); s_valid = 1'b0;
        chk("R6 bus held in idle", dac_data, 8'h80);

        send(2'b01);
        wake_len(0, n);
        chk("R4 short wait cycles", n, SHORT_EXP);

        s_valid = 1'b1; s_data = 8'h42; step(); s_valid = 1'b0;
        chk("R6 accept", dac_data, 8'h42);
        send(2'b10);
        bad = 0;
        for (int i = 0; i < 4; i++) begin
            if (out_valid) bad++;
            step();
        end
        chk("R9 pulse dropped", bad, 0);

        send(2'b01);
        wake_len(20, n);
        chk("R8 run during wake no restart", n, SHORT_EXP);

        send(2'b10);
        send(2'b01);
        for (int i = 0; i < 10; i++) step();
        send(2'b11);
        chk("R5 abort to off", mode_st, 2'b00);
        chk("R2 off pins", pins(), 3'b101);
        send(2'b01);
        wake_len(0, n);
        chk("R5 full long wait after abort", n, LONG_EXP);

        send(2'b11);
        send(2'b01);
        for (int i = 0; i < 30; i++) step();
        send(2'b10);
        chk("R5 abort to idle", mode_st, 2'b01);
        send(2'b01);
        wake_len(0, n);
        chk("R5 short wait after abort", n, SHORT_EXP);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200_000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule